// File: doc/BRIEF.md
# Window Watchdog Supervisor with Start-up Escalation

This block supervises a microcontroller through a watchdog with two phases. After a power-on reset, and after every reset it requests itself, it runs a start-up phase. The host must serve the watchdog before a fixed initial timeout runs out. One missed start-up deadline gives a reset pulse and a fresh start-up phase. A second missed deadline in a row, with no good serve in between, locks the block into a fail-safe state. Only an external power-on reset releases that state.

When the surrounding mode controller reports a rising edge on its normal-mode indication, the supervisor switches to window checking. Each serve must land in the second half of the programmed period. The period is a base unit times one of ten period steps, scaled by a prescaler factor of one, two, four or eight. A serve that comes too early, a period that expires with no serve, and a serve with a bad code all lead to the same result: a reset pulse and a return to the start-up phase. A status field records which of these events caused the last reset.

The host serves the watchdog with a single-cycle strobe. The strobe carries a mode code, a period select and a prescaler select. A good serve restarts the timer, and the selects it carries apply from the period that the serve starts. The states are STARTUP, WINDOW, RESET_PULSE and FAILSAFE. The transitions are:
- STARTUP to WINDOW on a normal-mode rise.
- STARTUP to RESET_PULSE on a first timeout or a bad serve.
- STARTUP to FAILSAFE on a second consecutive timeout.
- WINDOW to RESET_PULSE on an early serve, a late (missing) serve or a bad serve.
- RESET_PULSE to STARTUP once the pulse is complete.
- FAILSAFE to STARTUP only through power-on reset.

Top module: `wdt_window_sup`

## Requirements
- R1: While `por_n` is low, and on its release, the block is in STARTUP with `rst_req`=0, `fail_safe`=0, `win_active`=0 and `cause_flags`=0.
- R2: In STARTUP the timer restarts from zero at each entry and at each good serve. If no serve arrives for INIT_CYC clock edges, `rst_req` rises after the INIT_CYC-th edge and `cause_flags` becomes 4'b1000 (start-up timeout, bit 3).
- R3: A start-up timeout that follows a start-up timeout, with no good serve between them, asserts `fail_safe` instead of `rst_req`. A good serve in STARTUP clears this strike, so a later timeout gives an ordinary reset pulse. `fail_safe` stays high until `por_n` goes low.
- R4: A rising edge on `normal_mode` while in STARTUP moves the block to WINDOW, where `win_active`=1 and the timer starts from zero.
- R5: In WINDOW, a good serve seen while the timer holds a value below period/2 causes a reset with `cause_flags`=4'b0001 (too early, bit 0).
- R6: In WINDOW, if no serve is seen by the edge where the timer holds period-1, a reset follows with `cause_flags`=4'b0010 (timeout, bit 1). A serve at timer value period/2 or at period-1 is accepted.
- R7: A serve whose code is not SERVE_CODE (default 2'b10), or whose period select is 10 or more, causes a reset with `cause_flags`=4'b0100 (bad code, bit 2). This applies in STARTUP and in WINDOW.
- R8: The period in cycles is UNIT_CYC×(period select+1)×2^(prescaler select). An accepted serve latches its selects, and the period it starts uses them.
- R9: `rst_req` stays high for exactly RST_CYC (16) consecutive cycles, with `win_active`=0. The block then returns to STARTUP with the timer cleared.
- R10: In FAILSAFE, serves and `normal_mode` edges have no effect: `rst_req`=0, `win_active`=0 and `fail_safe`=1.
- R11: `cause_flags` has at most one bit set. It holds the cause of the most recent reset or fail-safe entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; the only release from fail-safe |
| normal_mode | input | 1 | Normal-mode indication from the mode controller; its rising edge enables window checking |
| srv_valid | input | 1 | Single-cycle serve strobe |
| srv_code | input | 2 | Mode code carried by the serve |
| srv_psel | input | 4 | Period select carried by the serve |
| srv_presc | input | 2 | Prescaler select carried by the serve |
| rst_req | output | 1 | Reset request pulse |
| fail_safe | output | 1 | Latched fail-safe indication |
| win_active | output | 1 | High while window checking is active |
| cause_flags | output | 4 | One-hot cause of the last reset: bit0 early, bit1 timeout, bit2 bad code, bit3 start-up timeout |

## Verification
The bench builds the block with UNIT_CYC=4, INIT_CYC=64 and RST_CYC=16. With these values a period of 20 or 32 cycles is short enough to test both window edges exactly: the serve one cycle before the half point, the serve at the half point and the serve at the last cycle. They also keep the two-strike start-up path to about 150 cycles, so the test can check the transition to fail-safe and the release by power-on reset, as well as the case where a serve clears the strike. Reprogramming from a 32-cycle period to a 20-cycle period then shows that the new selects govern the next timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP  = 2'd0,
        ST_WINDOW   = 2'd1,
        ST_RSTPULSE = 2'd2,
        ST_FAILSAFE = 2'd3
    } wdt_state_e;

    // one-hot cause encoding, bit positions fixed by the status port
    localparam logic [3:0] CAUSE_NONE  = 4'b0000;
    localparam logic [3:0] CAUSE_EARLY = 4'b0001;
    localparam logic [3:0] CAUSE_LATE  = 4'b0010;
    localparam logic [3:0] CAUSE_CODE  = 4'b0100;
    localparam logic [3:0] CAUSE_START = 4'b1000;

endpackage

// File: rtl/wdt_period_calc.sv
module wdt_period_calc #(
    parameter int UNIT_CYC = 8,
    parameter int CNT_W    = 16
) (
    input  logic [3:0]       psel,
    input  logic [1:0]       presc,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] half
);
    logic [CNT_W-1:0] base;

    always_comb begin
        base   = CNT_W'(UNIT_CYC * (int'(psel) + 1));
        period = base << presc;
        half   = period >> 1;
    end
endmodule

// File: rtl/wdt_srv_check.sv
module wdt_srv_check #(
    parameter int         CNT_W       = 16,
    parameter int         NUM_PERIODS = 10,
    parameter logic [1:0] SERVE_CODE  = 2'b10
) (
    input  logic             in_window,
    input  logic [1:0]       code,
    input  logic [3:0]       psel,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half,
    output logic             bad,
    output logic             early
);
    localparam logic [3:0] PSEL_LIMIT = 4'(NUM_PERIODS);

    always_comb begin
        bad   = (code != SERVE_CODE) || (psel >= PSEL_LIMIT);
        early = in_window && (cnt < half);
    end
endmodule

// File: rtl/wdt_window_sup.sv
module wdt_window_sup #(
    parameter int         UNIT_CYC   = 8,
    parameter int         INIT_CYC   = 256,
    parameter int         RST_CYC    = 16,
    parameter int         CNT_W      = 16,
    parameter logic [1:0] SERVE_CODE = 2'b10
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       normal_mode,
    input  logic       srv_valid,
    input  logic [1:0] srv_code,
    input  logic [3:0] srv_psel,
    input  logic [1:0] srv_presc,
    output logic       rst_req,
    output logic       fail_safe,
    output logic       win_active,
    output logic [3:0] cause_flags
);
    import wdt_pkg::*;

    localparam int               PW        = $clog2(RST_CYC + 1);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
    localparam logic [PW-1:0]    RST_LAST  = PW'(RST_CYC - 1);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PW-1:0]    pcnt_q, pcnt_d;
    logic             strike_q, strike_d;
    logic [3:0]       psel_q, psel_d;
    logic [1:0]       presc_q, presc_d;
    logic [3:0]       cause_q, cause_d;
    logic             norm_q;

    logic             norm_rise;
    logic [CNT_W-1:0] period, half;
    logic             srv_bad, srv_early;
    logic             early_hit;

    wdt_period_calc #(.UNIT_CYC(UNIT_CYC), .CNT_W(CNT_W)) u_period (
        .psel   (psel_q),
        .presc  (presc_q),
        .period (period),
        .half   (half)
    );

    wdt_srv_check #(.CNT_W(CNT_W), .NUM_PERIODS(10), .SERVE_CODE(SERVE_CODE)) u_check (
        .in_window (state_q == ST_WINDOW),
        .code      (srv_code),
        .psel      (srv_psel),
        .cnt       (cnt_q),
        .half      (half),
        .bad       (srv_bad),
        .early     (srv_early)
    );

    assign norm_rise = normal_mode && !norm_q;
    assign early_hit = srv_valid && !srv_bad && srv_early;

    // next-state and datapath decisions
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + 1'b1;
        pcnt_d   = '0;
        strike_d = strike_q;
        psel_d   = psel_q;
        presc_d  = presc_q;
        cause_d  = cause_q;
        unique case (state_q)
            ST_STARTUP: begin
                if (srv_valid) begin
                    if (srv_bad) begin
                        state_d = ST_RSTPULSE;
                        cause_d = CAUSE_CODE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d    = '0;
                        strike_d = 1'b0;
                        psel_d   = srv_psel;
                        presc_d  = srv_presc;
                    end
                end else if (norm_rise) begin
                    state_d = ST_WINDOW;
                    cnt_d   = '0;
                end else if (cnt_q == INIT_LAST) begin
                    cnt_d   = '0;
                    cause_d = CAUSE_START;
                    if (strike_q) begin
                        state_d = ST_FAILSAFE;
                    end else begin
                        state_d  = ST_RSTPULSE;
                        strike_d = 1'b1;
                    end
                end
            end
            ST_WINDOW: begin
                if (srv_valid) begin
                    cnt_d = '0;
                    if (srv_bad) begin
                        state_d = ST_RSTPULSE;
                        cause_d = CAUSE_CODE;
                    end else if (srv_early) begin
                        state_d = ST_RSTPULSE;
                        cause_d = CAUSE_EARLY;
                    end else begin
                        strike_d = 1'b0;
                        psel_d   = srv_psel;
                        presc_d  = srv_presc;
                    end
                end else if (cnt_q == period - 1'b1) begin
                    state_d = ST_RSTPULSE;
                    cause_d = CAUSE_LATE;
                    cnt_d   = '0;
                end
            end
            ST_RSTPULSE: begin
                cnt_d = '0;
                if (pcnt_q == RST_LAST) begin
                    state_d = ST_STARTUP;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end
            ST_FAILSAFE: begin
                cnt_d = '0;
            end
            default: begin
                state_d = ST_STARTUP;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q  <= ST_STARTUP;
            cnt_q    <= '0;
            pcnt_q   <= '0;
            strike_q <= 1'b0;
            psel_q   <= '0;
            presc_q  <= '0;
            cause_q  <= CAUSE_NONE;
            norm_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            pcnt_q   <= pcnt_d;
            strike_q <= strike_d;
            psel_q   <= psel_d;
            presc_q  <= presc_d;
            cause_q  <= cause_d;
            norm_q   <= normal_mode;
        end
    end

    // outputs
    always_comb begin
        rst_req     = 1'b0;
        fail_safe   = 1'b0;
        win_active  = 1'b0;
        cause_flags = cause_q;
        unique case (state_q)
            ST_STARTUP:  ;
            ST_WINDOW:   win_active = 1'b1;
            ST_RSTPULSE: rst_req    = 1'b1;
            ST_FAILSAFE: fail_safe  = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/wdt_window_sup_chk.sv
module wdt_window_sup_chk #(
    parameter int RST_CYC = 16
) (
    input logic       clk,
    input logic       por_n,
    input logic       rst_req,
    input logic       fail_safe,
    input logic       win_active,
    input logic [3:0] cause_flags,
    input logic       early_hit
);
    logic [7:0] hi_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       hi_len <= '0;
        else if (rst_req) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_req) |-> hi_len == 8'(RST_CYC)); // R9
    AST_PULSE_NO_WIN: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> !win_active && !fail_safe); // R9
    AST_FS_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        fail_safe |-> !rst_req && !win_active); // R10
    AST_FS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        fail_safe |=> fail_safe); // R3
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause_flags)); // R11
    AST_RST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_req) |-> cause_flags != 4'b0000); // R11
    AST_EARLY_RESET: assert property (@(posedge clk) disable iff (!por_n)
        early_hit && win_active |=> rst_req && cause_flags == 4'b0001); // R5
    AST_WIN_EXIT: assert property (@(posedge clk) disable iff (!por_n)
        $fell(win_active) |-> rst_req); // R6
endmodule

bind wdt_window_sup wdt_window_sup_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_req     (rst_req),
    .fail_safe   (fail_safe),
    .win_active  (win_active),
    .cause_flags (cause_flags),
    .early_hit   (early_hit)
);

// File: tb/wdt_window_sup_test.sv
module wdt_window_sup_test;

    localparam int UNIT = 4;
    localparam int INIT = 64;
    localparam int RSTC = 16;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       normal_mode = 1'b0;
    logic       srv_valid = 1'b0;
    logic [1:0] srv_code = 2'b00;
    logic [3:0] srv_psel = 4'd0;
    logic [1:0] srv_presc = 2'd0;
    logic       rst_req, fail_safe, win_active;
    logic [3:0] cause_flags;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_window_sup #(
        .UNIT_CYC(UNIT), .INIT_CYC(INIT), .RST_CYC(RSTC), .CNT_W(16), .SERVE_CODE(2'b10)
    ) uut (
        .clk(clk), .por_n(por_n), .normal_mode(normal_mode),
        .srv_valid(srv_valid), .srv_code(srv_code), .srv_psel(srv_psel), .srv_presc(srv_presc),
        .rst_req(rst_req), .fail_safe(fail_safe), .win_active(win_active), .cause_flags(cause_flags)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_e(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_on();
        @(negedge clk);
        normal_mode = 1'b0;
        srv_valid = 1'b0;
        por_n = 1'b0;
        wait_e(3);
        por_n = 1'b1;
    endtask

    task automatic serve(logic [1:0] code, logic [3:0] ps, logic [1:0] pr);
        srv_valid = 1'b1;
        srv_code  = code;
        srv_psel  = ps;
        srv_presc = pr;
        @(negedge clk);
        srv_valid = 1'b0;
    endtask

    task automatic enter_window();
        normal_mode = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        power_on();
        chk("R1", "rst_req", rst_req, 0);
        chk("R1", "fail_safe", fail_safe, 0);
        chk("R1", "win_active", win_active, 0);
        chk("R1", "cause_flags", cause_flags, 0);
    endtask

    task automatic t_startup_failsafe();
        power_on();
        wait_e(INIT - 1);
        chk("R2", "rst_req before timeout", rst_req, 0);
        wait_e(1);
        chk("R2", "rst_req at timeout", rst_req, 1);
        chk("R2", "cause start", cause_flags, 8);
        wait_e(RSTC - 1);
        chk("R9", "rst_req last pulse cycle", rst_req, 1);
        wait_e(1);
        chk("R9", "rst_req after pulse", rst_req, 0);
        wait_e(INIT - 1);
        chk("R3", "fail_safe before second timeout", fail_safe, 0);
        wait_e(1);
        chk("R3", "fail_safe after second timeout", fail_safe, 1);
        chk("R3", "no pulse on second timeout", rst_req, 0);
        serve(2'b10, 4'd3, 2'd1);
        enter_window();
        wait_e(5);
        chk("R10", "fail_safe kept", fail_safe, 1);
        chk("R10", "win_active stays low", win_active, 0);
        chk("R10", "rst_req stays low", rst_req, 0);
        power_on();
        chk("R10", "fail_safe cleared by por", fail_safe, 0);
    endtask

    task automatic t_strike_cleared();
        power_on();
        wait_e(INIT + RSTC);
        chk("R2", "back in startup", rst_req, 0);
        serve(2'b10, 4'd0, 2'd0);
        wait_e(INIT - 1);
        chk("R3", "timer restarted by serve", rst_req, 0);
        wait_e(1);
        chk("R3", "ordinary pulse after cleared strike", rst_req, 1);
        chk("R3", "no fail_safe after cleared strike", fail_safe, 0);
    endtask

    task automatic t_window_ok_and_reprogram();
        power_on();
        serve(2'b10, 4'd3, 2'd1);          // period 4*4*2 = 32, half 16
        enter_window();
        chk("R4", "win_active after rise", win_active, 1);
        wait_e(16);
        serve(2'b10, 4'd3, 2'd1);          // seen at timer 16
        chk("R6", "serve at half accepted", rst_req, 0);
        wait_e(31);
        serve(2'b10, 4'd4, 2'd0);          // seen at timer 31; next period 20
        chk("R6", "serve at last cycle accepted", rst_req, 0);
        chk("R6", "still in window", win_active, 1);
        wait_e(19);
        chk("R8", "new period not yet expired", rst_req, 0);
        wait_e(1);
        chk("R8", "timeout at new period", rst_req, 1);
        chk("R6", "cause late", cause_flags, 2);
        chk("R9", "window off during pulse", win_active, 0);
        wait_e(RSTC);
        chk("R9", "back to startup", win_active, 0);
        chk("R9", "pulse ended", rst_req, 0);
    endtask

    task automatic t_early();
        power_on();
        serve(2'b10, 4'd3, 2'd1);
        enter_window();
        wait_e(15);
        serve(2'b10, 4'd3, 2'd1);          // seen at timer 15 < 16
        chk("R5", "early serve resets", rst_req, 1);
        chk("R5", "cause early", cause_flags, 1);
    endtask

    task automatic t_bad_code();
        power_on();
        serve(2'b10, 4'd3, 2'd1);
        enter_window();
        wait_e(16);
        serve(2'b01, 4'd3, 2'd1);
        chk("R7", "wrong code resets", rst_req, 1);
        chk("R7", "cause code", cause_flags, 4);
        wait_e(RSTC);
        chk("R7", "startup after code reset", rst_req, 0);
        serve(2'b10, 4'd10, 2'd0);
        chk("R7", "period select 10 resets", rst_req, 1);
        chk("R11", "cause code one-hot", cause_flags, 4);
    endtask

    initial begin
        t_reset_state();
        t_startup_failsafe();
        t_strike_cleared();
        t_window_ok_and_reprogram();
        t_early();
        t_bad_code();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule